// File: doc/BRIEF.md
# Wait-State Slave Handshake Interface

This block is the slave end of a plain valid/ready link. A master raises `bus_valid` and holds a byte on `bus_data`. The slave does not answer at once. It counts a fixed number of clock edges and only then raises `bus_ready`. Once ready is up, every further edge that still sees valid high accepts one beat. Each accepted byte is copied into `cap_data`, and `cap_stb` is pulsed so that downstream logic can take the byte.

All decisions are made on clocked values. Valid is sampled at each rising edge. The transfer path sees ready only after its own register stage, so the first beat is accepted one edge after ready rises. As soon as an edge samples valid low, ready drops and the wait count starts again from zero. A later request therefore waits the full delay again.

Top module: `wss_slave`

## Requirements
- R1: The data path is `DW` bits wide (default 8), and a captured byte equals the `bus_data` value sampled at the accepting edge.
- R2: Let the first rising edge that samples `bus_valid` high be edge 0, with valid held high on every edge after it. Then `bus_ready` is first high after edge `WAIT` (default 4, so after the fourth edge following edge 0), and it is low before that.
- R3: After any rising edge that samples `bus_valid` low, `bus_ready` is low and the wait count is zero.
- R4: While `bus_valid` stays high, the wait count stops at `WAIT`, and `bus_ready` stays high once it has risen.
- R5: A beat is accepted at an edge only when that edge samples `bus_valid` high and `bus_ready` was already high before the edge. The first accepted beat of a request is at edge `WAIT+1`.
- R6: After each accepting edge, `cap_stb` is high for that one cycle and `cap_data` holds the accepted byte. After any other edge, `cap_stb` is low and `cap_data` keeps its previous value.
- R7: A synchronous active-high `rst` clears `bus_ready`, the wait count, `cap_data` and `cap_stb` at the next edge, even while `bus_valid` is high.
- R8: When valid drops and later rises again, or when reset is released under a high valid, the full `WAIT`-edge delay applies again before ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request from the master |
| bus_data | input | DW | Byte offered by the master |
| bus_ready | output | 1 | Registered ready after the wait state |
| cap_data | output | DW | Last accepted byte |
| cap_stb | output | 1 | One-cycle pulse per accepted beat |

## Verification
The requests are held high for different lengths. A request shorter than the wait never sees ready. A request exactly one edge longer than the wait raises ready but accepts no beat, which separates the ready timing from the transfer timing. Longer requests accept several beats. Gaps of zero and several idle edges between requests show whether the count really restarts. Other runs change the data on every beat while streaming, and apply reset in the middle of a request with valid still high. These tell apart a design that captures stale data from one that captures the current byte, and a design that clears its state from one that carries the count across a drop or a reset.

// File: rtl/wss_pkg.sv
package wss_pkg;
  parameter int unsigned WSS_DW   = 8;
  parameter int unsigned WSS_WAIT = 4;
endpackage

// File: rtl/wss_wait_gen.sv
module wss_wait_gen #(
  parameter int unsigned WAIT = wss_pkg::WSS_WAIT
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  output logic ready_o
);
  localparam int unsigned CW = (WAIT < 1) ? 1 : $clog2(WAIT + 1);
  localparam logic [CW-1:0] LIM = CW'(WAIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (!valid_i) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (cnt < LIM) begin
      cnt     <= cnt + 1'b1;
    end else begin
      ready_o <= 1'b1;
    end
  end

  // R3: a low sample of valid drops ready and clears the count
  p_drop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!ready_o && cnt == '0));
  // R2: ready can only rise after the count has reached its limit
  p_rise_after_wait_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(cnt) == LIM));
  // R4: a full count holds and ready stays up while valid stays high
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cnt == LIM) |=> (cnt == LIM && ready_o));
endmodule

// File: rtl/wss_capture.sv
module wss_capture #(
  parameter int unsigned DW = wss_pkg::WSS_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          ready_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          stb_o
);
  logic take;
  assign take = valid_i && ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= take;
      if (take) data_o <= data_i;
    end
  end

  // R6: an accepting edge yields a strobe with the sampled byte (R1)
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> (stb_o && data_o == $past(data_i)));
  // R5: no strobe without both sampled valid and registered ready
  p_no_beat_r5: assert property (@(posedge clk) disable iff (rst)
    !take |=> (!stb_o && $stable(data_o)));
endmodule

// File: rtl/wss_slave.sv
module wss_slave #(
  parameter int unsigned DW   = wss_pkg::WSS_DW,
  parameter int unsigned WAIT = wss_pkg::WSS_WAIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_data,
  output logic          bus_ready,
  output logic [DW-1:0] cap_data,
  output logic          cap_stb
);
  wss_wait_gen #(.WAIT(WAIT)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .valid_i (bus_valid),
    .ready_o (bus_ready)
  );

  wss_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .valid_i (bus_valid),
    .ready_i (bus_ready),
    .data_i  (bus_data),
    .data_o  (cap_data),
    .stb_o   (cap_stb)
  );

  // R5: first beat of a request never coincides with the rise of ready
  p_beat_after_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> !cap_stb);
endmodule

// File: tb/tb_wss_slave.sv
`timescale 1ns/1ps
module tb_wss_slave;
  localparam int DW   = wss_pkg::WSS_DW;
  localparam int WAIT = wss_pkg::WSS_WAIT;
  localparam int NV   = 7;
  // each entry: {cycles valid high, byte, idle cycles after drop}
  localparam logic [23:0] VEC [NV] = '{
    {8'd8,  8'hA5, 8'd2},
    {8'd5,  8'h3C, 8'd1},
    {8'd4,  8'h77, 8'd0},
    {8'd6,  8'hFF, 8'd0},
    {8'd10, 8'h00, 8'd3},
    {8'd1,  8'h5A, 8'd1},
    {8'd12, 8'h81, 8'd1}
  };

  logic clk = 1'b0;
  logic rst;
  logic bus_valid;
  logic [DW-1:0] bus_data;
  logic bus_ready;
  logic [DW-1:0] cap_data;
  logic cap_stb;
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [DW-1:0] exp_cap;

  always #10 clk = ~clk;

  wss_slave dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_data(bus_data),
    .bus_ready(bus_ready), .cap_data(cap_data), .cap_stb(cap_stb)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic step_chk(input string req, input logic er, input logic es);
    @(posedge clk); #1;
    chk({req, " ready"}, DW'(bus_ready), DW'(er));
    chk({req, " strobe"}, DW'(cap_stb), DW'(es));
    chk({req, " data"}, cap_data, exp_cap);
  endtask

  task automatic burst(input int n, input logic [DW-1:0] d, input int gap);
    for (int k = 0; k < n; k++) begin
      bus_valid = 1'b1; bus_data = d;
      if (k >= WAIT + 1) exp_cap = d;
      step_chk((k == WAIT) ? "R2" : (k > WAIT ? "R5" : "R4"), k >= WAIT, k >= WAIT + 1);
    end
    bus_valid = 1'b0; bus_data = ~d;
    step_chk("R3", 1'b0, 1'b0);
    for (int g = 0; g < gap; g++) step_chk("R8", 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_valid = 1'b0; bus_data = '0; exp_cap = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset ready", DW'(bus_ready), '0);
    chk("R7 reset strobe", DW'(cap_stb), '0);
    chk("R7 reset data", cap_data, '0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++)
      burst(int'(VEC[i][23:16]), VEC[i][15:8], int'(VEC[i][7:0]));

    // R6: data changing on every beat while streaming, R1 width-exact bytes
    for (int k = 0; k < WAIT + 5; k++) begin
      bus_valid = 1'b1; bus_data = DW'(8'h10 + k * 8'h11);
      if (k >= WAIT + 1) exp_cap = bus_data;
      step_chk("R6", k >= WAIT, k >= WAIT + 1);
    end

    // R7: reset mid-request with valid still high
    rst = 1'b1; exp_cap = '0;
    step_chk("R7", 1'b0, 1'b0);
    // R8: release reset under high valid, the full delay restarts
    rst = 1'b0;
    for (int k = 0; k < WAIT + 3; k++) begin
      bus_valid = 1'b1; bus_data = 8'hC3;
      if (k >= WAIT + 1) exp_cap = 8'hC3;
      step_chk("R8", k >= WAIT, k >= WAIT + 1);
    end
    bus_valid = 1'b0;
    step_chk("R3", 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule